// File: doc/BRIEF.md
# Pipelined Loop Stage Sequencer

This block drives a software-pipelined inner loop from one preloaded kernel instruction. The kernel is a set of operation slots. Each slot holds an operation word and a stage tag that says which loop stage the operation belongs to. After a start command, the block steps once per clock and keeps an active-stage mask. It fills that mask one stage per step, holds it full while the loop is in steady state, and then drains it one stage per step. On every step it sends out the kernel word with each slot enabled only if that slot's stage is active. Disabled slots are driven as no-ops. The prologue and the epilogue are therefore never stored as separate code.

The stage count S and the iteration count N are given with the start command. S may be any value from 1 to SMAX. Stage k of iteration i runs in the same step as stage k-1 of iteration i+1. The whole loop takes N+S-1 steps. A one-cycle done pulse follows the last step, and the block then returns to idle.

Top module: `loop_stage_seq`

## Requirements
- R1: After reset, busy_o, done_o, active_o, op_en_o and op_o are all zero, and phase_o reads idle (0).
- R2: A start is accepted only when the block is not busy, iters_i is at least 1, and stages_i is between 1 and SMAX. Any other start has no effect: the block stays idle, no done pulse appears, and all outputs stay zero.
- R3: On the first step, which is the cycle after the accepting clock edge, only stage 1 is active (active_o bit 0).
- R4: On step j (counting from 0), active_o bit k is 1 exactly when k < S and 0 <= j-k < N. Each step shifts the mask up by one bit. A 1 enters bit 0 while iterations are still being issued, and a 0 enters once all N iterations have been issued.
- R5: The kernel phase, in which all S stages are active, lasts N-S+1 steps when N >= S. It never occurs when N < S.
- R6: In the epilogue, stage 1 is inactive and at least one higher stage is active. Stages retire one per step until none are left.
- R7: busy_o is high for exactly N+S-1 cycles. done_o is high for exactly one cycle, which is the cycle right after the last step. busy_o is low during that done cycle.
- R8: op_en_o[s] equals active_o[t], where t is slot s's tag (t selects stage t+1). Slot s of op_o carries the latched operation word when that slot is enabled, and all zeros (a no-op) otherwise.
- R9: The stage count, the iteration count, the operation words and the tags are captured at the accepting edge. Changes to these inputs during a run do not affect that run.
- R10: phase_o encodes the phase as follows: 0 is idle, 1 is prologue (stage 1 active and not all S stages active), 2 is kernel (all S stages active), and 3 is epilogue.
- R11: A start presented in the done cycle is accepted. The next run's first step then follows immediately after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command |
| stages_i | input | SW ($clog2(SMAX+1)) | Stage count S |
| iters_i | input | CNT_W | Iteration count N |
| slot_op_i | input | NSLOT*OP_W | Kernel operation words, slot 0 in the low bits |
| slot_tag_i | input | NSLOT*TW ($clog2(SMAX)) | Stage tag per slot, 0-based |
| op_o | output | NSLOT*OP_W | Gated instruction word |
| op_en_o | output | NSLOT | Per-slot enable |
| active_o | output | SMAX | Active-stage mask, bit 0 is stage 1 |
| phase_o | output | 2 | Current phase |
| busy_o | output | 1 | A loop is in progress |
| done_o | output | 1 | One-cycle end-of-loop pulse |

## Verification
The hardest situations to reach from the ports are runs with N < S and runs that restart right away. In an N < S run the prologue turns straight into the epilogue, so the mask never becomes full. A restart reuses the done cycle as the accepting cycle. The stimulus sets up both of these deliberately. It runs N=2 with S=4, and it raises start exactly in the cycle in which done is expected. It also changes every captured input in the middle of a run and retries start while the block is busy. The behavioural model then shows whether the run kept its latched kernel.

// File: rtl/loop_stage_seq_pkg.sv
package loop_stage_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRO  = 2'd1,
    PH_KER  = 2'd2,
    PH_EPI  = 2'd3
  } phase_e;
endpackage

// File: rtl/stage_mask_gen.sv
module stage_mask_gen
  import loop_stage_seq_pkg::*;
#(
  parameter int SMAX  = 4,
  parameter int CNT_W = 16,
  localparam int SW   = $clog2(SMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SW-1:0]    stages_i,
  input  logic [CNT_W-1:0] iters_i,
  output logic             load_o,
  output logic [SMAX-1:0]  active_o,
  output phase_e           phase_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [SMAX-1:0]  mask_q, smask_q, smask_d, mask_nxt;
  logic [CNT_W-1:0] remain_q;
  logic             in_bit, accept;

  assign accept = start_i && !busy_q && (iters_i != '0) &&
                  (stages_i != '0) && (int'(stages_i) <= SMAX);
  assign in_bit = (remain_q != '0);
  assign mask_nxt = {mask_q[SMAX-2:0], in_bit} & smask_q;

  always_comb begin
    for (int k = 0; k < SMAX; k++) smask_d[k] = (k < int'(stages_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      mask_q   <= '0;
      smask_q  <= '0;
      remain_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        smask_q  <= smask_d;
        mask_q   <= {{(SMAX-1){1'b0}}, 1'b1};
        remain_q <= iters_i - 1'b1;
      end else if (busy_q) begin
        if (in_bit) remain_q <= remain_q - 1'b1;
        if (mask_nxt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          mask_q <= '0;
        end else begin
          mask_q <= mask_nxt;
        end
      end
    end
  end

  always_comb begin
    if (!busy_q)                phase_o = PH_IDLE;
    else if (mask_q == smask_q) phase_o = PH_KER;
    else if (mask_q[0])         phase_o = PH_PRO;
    else                        phase_o = PH_EPI;
  end

  assign load_o   = accept;
  assign active_o = mask_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7: the end of a run is always followed by done
  p_fall_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  // R4: while busy, the mask is nonzero and stays inside the configured stages
  p_mask_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ((mask_q != '0) && ((mask_q & ~smask_q) == '0)));
  // R6: once the kernel is left, no prologue step returns
  p_no_refill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !mask_q[0] && !accept) |=> (!busy_q || !mask_q[0]));
  // R2: while idle, the mask stays clear unless a start is accepted
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !accept) |=> (mask_q == '0));
endmodule

// File: rtl/slot_gate.sv
module slot_gate #(
  parameter int NSLOT = 4,
  parameter int OP_W  = 8,
  parameter int SMAX  = 4,
  localparam int TW   = $clog2(SMAX)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NSLOT*OP_W-1:0] slot_op_i,
  input  logic [NSLOT*TW-1:0]   slot_tag_i,
  input  logic [SMAX-1:0]       active_i,
  output logic [NSLOT*OP_W-1:0] op_o,
  output logic [NSLOT-1:0]      op_en_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [OP_W-1:0] op_q;
    logic [TW-1:0]   tag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        op_q  <= '0;
        tag_q <= '0;
      end else if (load_i) begin
        op_q  <= slot_op_i[s*OP_W +: OP_W];
        tag_q <= slot_tag_i[s*TW +: TW];
      end
    end

    assign op_en_o[s]           = active_i[tag_q];
    assign op_o[s*OP_W +: OP_W] = op_en_o[s] ? op_q : '0;

    // R8: with no stage active, the slot is a no-op
    p_idle_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i == '0) |-> (!op_en_o[s] && (op_o[s*OP_W +: OP_W] == '0)));
  end
endmodule

// File: rtl/loop_stage_seq.sv
module loop_stage_seq
  import loop_stage_seq_pkg::*;
#(
  parameter int SMAX  = 4,
  parameter int NSLOT = 4,
  parameter int OP_W  = 8,
  parameter int CNT_W = 16,
  localparam int SW   = $clog2(SMAX + 1),
  localparam int TW   = $clog2(SMAX)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [SW-1:0]         stages_i,
  input  logic [CNT_W-1:0]      iters_i,
  input  logic [NSLOT*OP_W-1:0] slot_op_i,
  input  logic [NSLOT*TW-1:0]   slot_tag_i,
  output logic [NSLOT*OP_W-1:0] op_o,
  output logic [NSLOT-1:0]      op_en_o,
  output logic [SMAX-1:0]       active_o,
  output logic [1:0]            phase_o,
  output logic                  busy_o,
  output logic                  done_o
);
  logic   load;
  phase_e phase;

  stage_mask_gen #(.SMAX(SMAX), .CNT_W(CNT_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stages_i (stages_i),
    .iters_i  (iters_i),
    .load_o   (load),
    .active_o (active_o),
    .phase_o  (phase),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  slot_gate #(.NSLOT(NSLOT), .OP_W(OP_W), .SMAX(SMAX)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .slot_op_i  (slot_op_i),
    .slot_tag_i (slot_tag_i),
    .active_i   (active_o),
    .op_o       (op_o),
    .op_en_o    (op_en_o)
  );

  assign phase_o = phase;

  // R10: a busy block never reports idle
  p_busy_phase_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (phase_o != 2'd0));
endmodule

// File: tb/loop_stage_seq_tb_top.sv
module loop_stage_seq_tb_top;
  localparam int SMAX = 4, NSLOT = 4, OP_W = 8, CNT_W = 16;
  localparam int SW = $clog2(SMAX + 1), TW = $clog2(SMAX);

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [SW-1:0] stages = '0;
  logic [CNT_W-1:0] iters = '0;
  logic [NSLOT*OP_W-1:0] slot_op = '0, op;
  logic [NSLOT*TW-1:0] slot_tag = '0;
  logic [NSLOT-1:0] op_en;
  logic [SMAX-1:0] active;
  logic [1:0] phase;
  logic busy, done;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;  // 125 MHz

  loop_stage_seq #(.SMAX(SMAX), .NSLOT(NSLOT), .OP_W(OP_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .stages_i(stages),
    .iters_i(iters), .slot_op_i(slot_op), .slot_tag_i(slot_tag),
    .op_o(op), .op_en_o(op_en), .active_o(active), .phase_o(phase),
    .busy_o(busy), .done_o(done));

  // behavioural reference state
  bit m_busy, m_done;
  int m_j, m_n, m_s, ker_seen;
  int m_tag[NSLOT];
  int m_op[NSLOT];

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(int k);
    return m_busy && k < m_s && (m_j - k) >= 0 && (m_j - k) < m_n;
  endfunction

  task automatic compare_all();
    logic [SMAX-1:0] ea;
    int cnt;
    logic [NSLOT-1:0] een;
    logic [NSLOT*OP_W-1:0] eop;
    logic [1:0] eph;
    cnt = 0;
    for (int k = 0; k < SMAX; k++) begin
      ea[k] = exp_bit(k);
      cnt += int'(ea[k]);
    end
    eop = '0;
    for (int s = 0; s < NSLOT; s++) begin
      een[s] = ea[m_tag[s]];
      if (een[s]) eop[s*OP_W +: OP_W] = OP_W'(m_op[s]);
    end
    if (!m_busy) eph = 2'd0;
    else if (cnt == m_s) eph = 2'd2;
    else if (ea[0]) eph = 2'd1;
    else eph = 2'd3;
    if (phase == 2'd2) ker_seen++;
    chk("R3/R4/R6", "active_o", active, ea);
    chk("R8", "op_en_o", op_en, een);
    chk("R8", "op_o", op, eop);
    chk("R7", "busy_o", busy, m_busy);
    chk("R7", "done_o", done, m_done);
    chk("R10", "phase_o", phase, eph);
  endtask

  // one clock: model advances with the inputs held since the last negedge
  task automatic tick();
    bit acc;
    acc = start && !m_busy && iters != 0 && stages != 0 && int'(stages) <= SMAX;
    m_done = 1'b0;
    if (acc) begin
      m_busy = 1'b1; m_j = 0; m_n = int'(iters); m_s = int'(stages);
      for (int s = 0; s < NSLOT; s++) begin
        m_tag[s] = int'(slot_tag[s*TW +: TW]);
        m_op[s]  = int'(slot_op[s*OP_W +: OP_W]);
      end
    end else if (m_busy) begin
      if (m_j + 1 < m_n + m_s - 1) m_j++;
      else begin m_busy = 1'b0; m_done = 1'b1; end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic load_kernel(int seed);
    for (int s = 0; s < NSLOT; s++) begin
      slot_op[s*OP_W +: OP_W] = OP_W'(seed * 37 + s * 29 + 1);
      slot_tag[s*TW +: TW]    = TW'(seed + s * 3);
    end
  endtask

  // R5: count kernel steps over one run
  task automatic run(int s, int n, int seed);
    int exp_k;
    load_kernel(seed);
    stages = SW'(s); iters = CNT_W'(n); start = 1'b1;
    ker_seen = 0;
    tick();
    start = 1'b0;
    while (m_busy || m_done) tick();
    exp_k = (n >= s) ? n - s + 1 : 0;
    chk("R5", "kernel steps", ker_seen, exp_k);
  endtask

  initial begin
    m_busy = 0; m_done = 0; m_j = 0; m_n = 0; m_s = 1;
    for (int s = 0; s < NSLOT; s++) begin m_tag[s] = 0; m_op[s] = 0; end
    #1;
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset active", active, 0);
    chk("R1", "reset op", op, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    compare_all();
    // R2: invalid starts ignored
    load_kernel(5);
    stages = 3; iters = 0; start = 1; tick(); tick();
    stages = 0; iters = 4; tick();
    stages = 5; iters = 4; tick();
    start = 0; tick(); tick();
    run(3, 5, 1);
    run(4, 2, 2);
    run(1, 3, 3);
    run(4, 4, 4);
    run(1, 1, 6);
    run(2, 7, 7);
    // R9 and R2: mid-run changes and a start while busy are ignored
    load_kernel(8);
    stages = 3; iters = 6; start = 1; tick();
    start = 0; tick();
    load_kernel(9); stages = 1; iters = 1; start = 1; tick(); tick();
    start = 0;
    while (m_busy) tick();
    // R11: the model is now in the done cycle; a start here must be accepted
    load_kernel(10); stages = 2; iters = 3; start = 1; tick();
    start = 0;
    while (m_busy || m_done) tick();
    tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule